// File: doc/BRIEF.md
# MII Collision and Heartbeat Generator

This block drives the MII collision indication of a 10/100 Ethernet PHY. Each cycle it samples a transmit-active strobe, a receive-active strobe, the duplex mode, the link speed and a heartbeat-enable control. It produces one registered output, `col`. In half duplex at either speed, `col` is high while transmit and receive overlap. In full duplex, `col` stays low at all times.

In 10 Mb/s half duplex with heartbeat enabled, the block also sends a signal-quality-error test pulse on `col` when each transmission ends. The pulse lasts 25 reference-clock cycles, which is 1 µs at the 25 MHz reference clock. A small state machine times the pulse. It has two states:
- `HB_IDLE`: waiting for a transmit end. The transition `start` moves it to `HB_PULSE` when a transmit falling edge is seen while heartbeat is allowed.
- `HB_PULSE`: timing the pulse with a counter. The transition `expire` returns it to `HB_IDLE` after the last pulse cycle.

All inputs are treated as synchronous to the clock. Reset is synchronous and active low.

Top module: `col_mii_gen`

## Requirements
- R1: In half duplex (`full_dup`=0), at either speed, if `tx_act` and `rx_act` are both 1 at a rising edge, `col` is 1 after that edge.
- R2: If `full_dup`=1 at a rising edge, `col` is 0 after that edge, whatever the other inputs and any pulse in progress.
- R3: A heartbeat starts at the first rising edge that samples `tx_act`=0 after an edge that sampled `tx_act`=1. It starts only if, at that edge, `full_dup`=0, `spd100`=0 (10 Mb/s) and `hb_en`=1. `col` is 1 from that edge on.
- R4: The heartbeat keeps `col` high for exactly `HB_CYCLES` (default 25) consecutive cycles.
- R5: While `rst_n`=0 at a rising edge, `col` goes to 0, any pulse is cancelled, and the stored transmit history is cleared.
- R6: A transmit end that is sampled while `hb_en`=0 or `full_dup`=1 produces no heartbeat.
- R7: At 100 Mb/s (`spd100`=1) no heartbeat is produced, even with `hb_en`=1.
- R8: A pulse in progress runs to its full length. A new transmission, or a transmit end during the pulse, does not shorten or restart it. An overlap of transmit and receive during the pulse is ORed onto `col`.
- R9: In half duplex, with no overlap and no heartbeat pending, `col` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| spd100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hb_en | input | 1 | Heartbeat (SQE test) enable |
| col | output | 1 | Registered collision indication |

## Verification
Every result of this block is due one rising edge after the inputs that cause it. An overlap, a full-duplex mask or the first heartbeat cycle all appear on `col` just after the edge that samples them. The bench drives inputs on the falling edge and updates its reference model at the rising edge. It then compares `col` at the next falling edge, so each check lands in the single cycle where its result is due. Pulse length is checked by counting the high cycles of `col` across a whole directed sequence. In that sequence `rx_act` is held low, so only the heartbeat can drive the output.

// File: rtl/col_pkg.sv
package col_pkg;
    typedef enum logic [0:0] {
        HB_IDLE  = 1'b0,
        HB_PULSE = 1'b1
    } hb_state_t;
endpackage

// File: rtl/col_tx_edge.sv
module col_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    output logic tx_fall
);
    logic tx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) tx_d <= 1'b0;
        else        tx_d <= tx_act;
    end

    assign tx_fall = tx_d & ~tx_act;

    // R3: a fall can only follow a cycle with transmit active
    AST_FALL_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_act |=> (tx_fall == !tx_act)); // R3
endmodule

// File: rtl/col_hb_fsm.sv
module col_hb_fsm
    import col_pkg::*;
#(
    parameter int HB_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_fall,
    input  logic hb_allow,
    output logic hb_req
);
    localparam int CW = (HB_CYCLES > 2) ? $clog2(HB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HB_CYCLES - 1);

    hb_state_t st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= HB_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state: start / expire
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            HB_IDLE: begin
                if (tx_fall && hb_allow) begin
                    st_n  = HB_PULSE;
                    cnt_n = CW'(1);
                end
            end
            HB_PULSE: begin
                if (cnt == LAST) begin
                    st_n  = HB_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                st_n  = HB_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        hb_req = 1'b0;
        unique case (st)
            HB_IDLE:  hb_req = tx_fall && hb_allow;
            HB_PULSE: hb_req = 1'b1;
            default:  hb_req = 1'b0;
        endcase
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HB_PULSE) |-> (cnt != '0 && cnt <= LAST)); // R4
    AST_HB_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HB_IDLE && tx_fall && hb_allow) |=> (st == HB_PULSE && cnt == CW'(1))); // R3
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HB_PULSE && cnt != LAST) |=> (st == HB_PULSE)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HB_IDLE && !hb_allow) |=> (st == HB_IDLE)); // R6
endmodule

// File: rtl/col_mii_gen.sv
module col_mii_gen #(
    parameter int HB_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    input  logic rx_act,
    input  logic full_dup,
    input  logic spd100,
    input  logic hb_en,
    output logic col
);
    logic tx_fall;
    logic hb_allow;
    logic hb_req;

    assign hb_allow = ~full_dup & ~spd100 & hb_en;

    col_tx_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_act  (tx_act),
        .tx_fall (tx_fall)
    );

    col_hb_fsm #(.HB_CYCLES(HB_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_fall  (tx_fall),
        .hb_allow (hb_allow),
        .hb_req   (hb_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) col <= 1'b0;
        else        col <= ~full_dup & ((tx_act & rx_act) | hb_req);
    end

    AST_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_dup && tx_act && rx_act) |=> col); // R1
    AST_FD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        full_dup |=> !col); // R2
    AST_FAST_NO_HB: assert property (@(posedge clk) disable iff (!rst_n)
        (spd100 && !(tx_act && rx_act) && !hb_req) |=> !col); // R7
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tx_act && rx_act) && !hb_req) |=> !col); // R9
endmodule

// File: tb/col_mii_gen_tb.sv
module col_mii_gen_tb_top;
    localparam int HB = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_act = 1'b0, rx_act = 1'b0, full_dup = 1'b0, spd100 = 1'b0, hb_en = 1'b0;
    logic col;

    int n_chk = 0, n_err = 0;
    int m_cnt = 0;
    bit m_txd = 0;
    bit exp_col = 0;
    string exp_tag = "R5";
    int highs = 0;

    always #5 clk = ~clk;

    col_mii_gen #(.HB_CYCLES(HB)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
        .full_dup(full_dup), .spd100(spd100), .hb_en(hb_en), .col(col)
    );

    function automatic string tag_of(bit rst, bit fd, bit hb, bit ov);
        if (!rst) return "R5";
        if (fd)   return "R2";
        if (hb && ov) return "R8";
        if (hb)   return "R3";
        if (ov)   return "R1";
        return "R9";
    endfunction

    task automatic check(string tag, bit act, bit expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: col actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(bit t, bit r);
        bit fall, hbq, ov;
        tx_act = t; rx_act = r;
        @(posedge clk);
        fall = m_txd && !t && !full_dup && !spd100 && hb_en;
        if (!rst_n) begin
            m_txd = 0; m_cnt = 0; exp_col = 0; exp_tag = "R5";
        end else begin
            hbq = fall || (m_cnt > 0);
            ov  = t && r;
            exp_col = !full_dup && (ov || hbq);
            exp_tag = tag_of(1'b1, full_dup, hbq, ov);
            if (m_cnt > 0) m_cnt = (m_cnt == HB - 1) ? 0 : m_cnt + 1;
            else if (fall) m_cnt = 1;
            m_txd = t;
        end
        @(negedge clk);
        check(exp_tag, col, exp_col);
        if (col === 1'b1) highs++;
    endtask

    task automatic set_mode(bit fd, bit s, bit h);
        full_dup = fd; spd100 = s; hb_en = h;
    endtask

    initial begin
        #2_000_000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        rst_n = 0;
        set_mode(0, 0, 1);
        step(1, 1); step(1, 1);                      // R5 reset holds col low
        rst_n = 1;
        step(0, 0);                                  // R9

        // R3/R4 pulse length in 10 Mb/s half duplex
        repeat (5) step(1, 0);
        highs = 0;
        repeat (40) step(0, 0);
        check("R4 length", highs == HB, 1'b1);

        // R7 no heartbeat at 100 Mb/s
        set_mode(0, 1, 1);
        repeat (4) step(1, 0);
        highs = 0;
        repeat (30) step(0, 0);
        check("R7 no pulse", highs == 0, 1'b1);

        // R6 no heartbeat with hb disabled, nor in full duplex
        set_mode(0, 0, 0);
        repeat (4) step(1, 0);
        highs = 0;
        repeat (30) step(0, 0);
        check("R6 hb off", highs == 0, 1'b1);
        set_mode(1, 0, 1);
        repeat (4) step(1, 1);
        highs = 0;
        repeat (30) step(0, 0);
        check("R2 full duplex", highs == 0, 1'b1);

        // R8 new transmission and fall during pulse do not alter its length
        set_mode(0, 0, 1);
        repeat (3) step(1, 0);
        highs = 0;
        repeat (5) step(0, 0);
        repeat (3) step(1, 0);
        repeat (40) step(0, 0);
        check("R8 length", highs == HB, 1'b1);

        // R1 overlap at 100 Mb/s half duplex
        set_mode(0, 1, 0);
        repeat (3) step(1, 1);

        // R5 reset mid-pulse cancels it
        set_mode(0, 0, 1);
        repeat (2) step(1, 0);
        step(0, 0); step(0, 0);
        rst_n = 0; step(0, 0);
        rst_n = 1;
        highs = 0;
        repeat (30) step(0, 0);
        check("R5 cancel", highs == 0, 1'b1);

        // constrained random: bursty tx/rx, rare mode changes
        for (int i = 0; i < 4000; i++) begin
            bit t, r;
            if ($urandom_range(0, 199) == 0)
                set_mode($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0);
            t = ($urandom_range(0, 9) < 6) ? tx_act : ~tx_act;
            r = ($urandom_range(0, 9) < 8) ? rx_act : ~rx_act;
            step(t, r);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule